// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation converter. A host writes one control byte that holds an enable, a conversion-clock choice, an input channel choice and a start/busy flag. Once started, the block waits through a sampling window. It then resolves the result one bit per conversion-clock tick, most significant bit first. On each tick it drives a trial code to an external DAC and reads back a single comparator bit.

The result register also shows progress. When sampling ends it is cleared, and a lone marker one enters at its top. After each decision the marker moves one place down, and the decided bit is left in the place the marker came from. The conversion is finished when the marker falls off the bottom. The busy flag then drops and a one-cycle done pulse fires. If the host clears the busy flag early, the register is frozen. The bits above the marker are valid, and the bits at and below it are lost.

All pins are plain control and status signals. Nothing on this block streams, so there is no valid/ready pair and no back-pressure. The control byte can be written at any time. Result and control are always readable.

Top module: `sar_seq`

## Requirements
- R1: After reset, `ctrl_q` reads 8'h03 (busy 0, enable 0, clock select 00, channel 11). `result_q` and `dac_code` are 0 and `done_pulse` is low.
- R2: The control byte is {busy[7], enable[6], 2'b00, clk_sel[3:2], chan[1:0]}. A write sets busy only if enable was already 1 before the write and the written byte keeps enable at 1. A write with enable 0 clears busy and stops any conversion. `adc_on` mirrors enable.
- R3: From the start write until the end of sampling (2 conversion ticks), `result_q` keeps the previous result and `sampling` is high. On the tick that ends sampling, `result_q` becomes 8'h80: cleared, with the marker at bit 7.
- R4: During conversion, `dac_code` equals `result_q`. It holds the bits decided so far, a 1 at the bit under test and 0 below it. `cmp_hi`=1 (input at or above the trial level) keeps the tested bit, and 0 clears it.
- R5: The eighth decision ends the conversion. `result_q` then holds the final code, busy reads 0, and `done_pulse` is high for exactly the one following cycle.
- R6: A write with busy 0 during sampling or conversion stops the block at once. After k decisions `result_q` holds (code & ~(8'hFF>>k)) | (8'h80>>k), it stays unchanged afterwards, and no done pulse follows.
- R7: With clock select 00, 01 or 10, one tick occurs every 16, 8 or 4 clock cycles, so a conversion takes 160, 80 or 40 cycles from the start write to the done pulse. With 11, one tick occurs every 4 `osc_tick` strobes.
- R8: `chan_sel` mirrors the channel field. 00, 01 and 10 select inputs 0 to 2, and 11 selects the internal fixed reference.
- R9: An abort write that lands on the same edge as the final decision wins. The final bit is not resolved, `result_q` holds the top 7 bits with bit 0 set, and no done pulse occurs.
- R10: A write with busy 1 and enable 1 while a conversion is running has no effect on its result or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe per internal oscillator period |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to write |
| ctrl_q | output | 8 | Control byte readback |
| result_q | output | 8 | Result register with progress marker |
| dac_code | output | 8 | Trial code to the DAC; 0 outside conversion |
| cmp_hi | input | 1 | Comparator: input at or above the trial level |
| chan_sel | output | 2 | Selected analog input |
| adc_on | output | 1 | Converter powered |
| sampling | output | 1 | Sample window active |
| done_pulse | output | 1 | One-cycle natural completion pulse |

## Verification
A host abort write can land on the same edge as the final bit decision. The bench provokes this by timing the write for cycle 10N-1 after a start at divide-by-4. It then checks three things: the result holds seven decided bits with the marker in bit 0, busy is low, and the done-pulse count has not moved. Because the scoreboard treats any done pulse arriving on an empty expectation queue as a failure, a completion that wrongly beats the abort is caught. A second overlap is a busy-1 write issued mid-conversion. For that case the scoreboard judges the completion cycle against the original start.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SAMPLE, PH_CONV} phase_t;

  typedef struct packed {
    logic       busy;
    logic       en;
    logic [1:0] rsvd;
    logic [1:0] clk_sel;
    logic [1:0] chan;
  } ctrl_t;

  localparam logic [1:0] CLK_SEL_OSC = 2'b11;
  localparam logic [1:0] CHAN_REF    = 2'b11;
endpackage

// File: rtl/sar_ctrl_reg.sv
module sar_ctrl_reg
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       finish,
  output ctrl_t      ctrl,
  output logic       start,
  output logic       abort
);
  ctrl_t wv;
  logic  wr_unused;

  assign wv        = ctrl_t'(wr_data);
  assign wr_unused = ^wv.rsvd;

  always_comb begin
    start = wr_en & ~ctrl.busy & wv.busy & wv.en & ctrl.en;
    abort = wr_en & ctrl.busy & (~wv.busy | ~wv.en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl.busy    <= 1'b0;
      ctrl.en      <= 1'b0;
      ctrl.rsvd    <= 2'b00;
      ctrl.clk_sel <= 2'b00;
      ctrl.chan    <= CHAN_REF;
    end else begin
      if (wr_en) begin
        ctrl.en      <= wv.en;
        ctrl.clk_sel <= wv.clk_sel;
        ctrl.chan    <= wv.chan;
      end
      if (start)               ctrl.busy <= 1'b1;
      else if (abort | finish) ctrl.busy <= 1'b0;
    end
  end

  assert_busy_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.busy) |-> $past(ctrl.en));

  assert_en_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> !ctrl.busy);
endmodule

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int BASE_DIV = 16,
  parameter int OSC_DIV  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  input  logic       osc_tick,
  output logic       tick
);
  localparam int MAX_DIV = (BASE_DIV > OSC_DIV) ? BASE_DIV : OSC_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             step;

  always_comb begin
    if (sel == sar_pkg::CLK_SEL_OSC) begin
      lim  = CNT_W'(OSC_DIV - 1);
      step = osc_tick;
    end else begin
      lim  = CNT_W'((BASE_DIV >> sel) - 1);
      step = 1'b1;
    end
    tick = run & step & (cnt >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) cnt <= '0;
    else if (step)                 cnt <= tick ? '0 : cnt + 1'b1;
  end

  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(tick)) |-> !tick);
endmodule

// File: rtl/sar_conv_core.sv
module sar_conv_core
  import sar_pkg::*;
#(
  parameter int RES_W        = 8,
  parameter int SAMPLE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] result,
  output logic [RES_W-1:0] dac_code,
  output logic             finish,
  output logic             sampling
);
  localparam int SC_W = $clog2(SAMPLE_TICKS + 1);

  phase_t          phase;
  logic [SC_W-1:0] scnt;
  logic [RES_W:0]  chain;
  logic [RES_W:0]  mark;
  logic [RES_W:0]  nxt;

  always_comb begin
    mark     = chain & (~chain + 1'b1);
    nxt      = (cmp_hi ? chain : (chain & ~mark)) | (mark >> 1);
    finish   = (phase == PH_CONV) & tick & ~abort & nxt[0];
    result   = chain[RES_W:1];
    sampling = (phase == PH_SAMPLE);
    dac_code = (phase == PH_CONV) ? result : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      scnt  <= '0;
      chain <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SAMPLE;
          scnt  <= '0;
        end
        PH_SAMPLE: if (tick) begin
          if (scnt == SC_W'(SAMPLE_TICKS - 1)) begin
            chain <= {1'b1, {RES_W{1'b0}}};
            phase <= PH_CONV;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        PH_CONV: if (tick) begin
          chain <= {nxt[RES_W:1], 1'b0};
          if (nxt[0]) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_marker_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV) |-> (result != '0));

  assert_sample_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && $past(phase) == PH_SAMPLE) |-> (result == {1'b1, {(RES_W-1){1'b0}}}));

  assert_abort_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort) |-> (chain == $past(chain)));

  assert_finish_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W        = 8,
  parameter int SAMPLE_TICKS = 2,
  parameter int BASE_DIV     = 16,
  parameter int OSC_DIV      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ctrl_q,
  output logic [RES_W-1:0] result_q,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_hi,
  output logic [1:0]       chan_sel,
  output logic             adc_on,
  output logic             sampling,
  output logic             done_pulse
);
  ctrl_t ctrl;
  logic  start, abort, finish, tick;

  sar_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .finish(finish), .ctrl(ctrl), .start(start), .abort(abort)
  );

  sar_tick_gen #(.BASE_DIV(BASE_DIV), .OSC_DIV(OSC_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl.busy), .restart(start),
    .sel(ctrl.clk_sel), .osc_tick(osc_tick), .tick(tick)
  );

  sar_conv_core #(.RES_W(RES_W), .SAMPLE_TICKS(SAMPLE_TICKS)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .tick(tick),
    .cmp_hi(cmp_hi), .result(result_q), .dac_code(dac_code),
    .finish(finish), .sampling(sampling)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_pulse <= 1'b0;
    else        done_pulse <= finish;
  end

  assign ctrl_q   = ctrl;
  assign chan_sel = ctrl.chan;
  assign adc_on   = ctrl.en;

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!ctrl.busy && $past(ctrl.busy)));

  assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
endmodule

// File: tb/sar_seq_tb.sv
`timescale 1ns/100ps
module sar_seq_tb;
  logic       clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_q, result_q, dac_code;
  logic [1:0] chan_sel;
  logic       adc_on, sampling, done_pulse, cmp_hi;
  logic [11:0] vin = '0;

  int n_run = 0, n_fail = 0, cyc = 0, start_cyc = 0, done_cnt = 0, oc = 0;
  int q_code[$];
  int q_cyc[$];
  logic [7:0] code, part, prev;
  int d0, nd;

  sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .result_q(result_q), .dac_code(dac_code), .cmp_hi(cmp_hi),
    .chan_sel(chan_sel), .adc_on(adc_on), .sampling(sampling), .done_pulse(done_pulse)
  );

  // modelled comparator: input scaled 16x finer than the DAC step
  assign cmp_hi = (vin >= {dac_code, 4'b0000});

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    oc       <= (oc == 2) ? 0 : oc + 1;
    osc_tick <= (oc == 2);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  function automatic logic [7:0] cw(bit busy, bit en, logic [1:0] sel, logic [1:0] ch);
    return {busy, en, 2'b00, sel, ch};
  endfunction

  task automatic wr(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start_conv(input logic [11:0] v, input logic [1:0] sel, input bit expect_done);
    vin = v;
    wr(cw(1'b1, 1'b1, sel, 2'b00));
    start_cyc = cyc;
    if (expect_done) begin
      q_code.push_back(int'(v[11:4]));
      q_cyc.push_back(sel == 2'b11 ? -1 : 10 * (16 >> sel));
    end
  endtask

  task automatic wait_idle();
    while (ctrl_q[7]) @(posedge clk);
    wait_cyc(2);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_pulse) begin
      done_cnt++;
      if (q_code.size() == 0) chk(1'b0, "R6", "unexpected done pulse", 1, 0);
      else begin
        int e, c;
        e = q_code.pop_front();
        c = q_cyc.pop_front();
        chk(int'(result_q) == e, "R5", "final code", result_q, e);
        chk(ctrl_q[7] == 1'b0, "R5", "busy cleared at done", ctrl_q[7], 0);
        if (c >= 0) chk(cyc - start_cyc == c, "R7", "cycles start to done", cyc - start_cyc, c);
      end
    end
  end

  initial begin
    #(100000 * 5);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk(ctrl_q == 8'h03, "R1", "ctrl after reset", ctrl_q, 8'h03);
    chk(result_q == 8'h00, "R1", "result after reset", result_q, 0);
    chk(dac_code == 8'h00 && !done_pulse, "R1", "dac/done after reset", dac_code, 0);

    // R2 start refused while enable was off
    wr(cw(1'b1, 1'b1, 2'b00, 2'b00));
    chk(ctrl_q[7] == 1'b0, "R2", "busy set with enable off", ctrl_q[7], 0);
    chk(adc_on == 1'b1, "R2", "enable written", adc_on, 1);
    wait_cyc(40);
    chk(done_cnt == 0, "R2", "no conversion ran", done_cnt, 0);

    // R8 channel mirror
    for (int ch = 0; ch < 4; ch++) begin
      wr(cw(1'b0, 1'b1, 2'b00, 2'(ch)));
      chk(chan_sel == 2'(ch) && ctrl_q[1:0] == 2'(ch), "R8", "channel select", chan_sel, ch);
    end

    // R5/R7 conversions over every clock source and several inputs
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 6; i++) begin
        logic [11:0] v;
        case (i)
          0: v = 12'h000;
          1: v = 12'hFFF;
          2: v = 12'h7FF;
          3: v = 12'h800;
          default: v = 12'($urandom_range(0, 4095));
        endcase
        start_conv(v, 2'(s), 1'b1);
        wait_idle();
      end
    end

    // R3 old result held through sampling, then cleared with marker
    prev = result_q;
    start_conv(12'h5A3, 2'b10, 1'b1);
    wait_cyc(4);
    chk(result_q == prev && sampling, "R3", "previous result during sampling", result_q, prev);
    wait_cyc(4);
    chk(result_q == 8'h80 && !sampling, "R3", "clear plus marker", result_q, 8'h80);
    wait_idle();

    // R4/R6 aborts at random decision counts
    for (int it = 0; it < 10; it++) begin
      int k, n;
      logic [1:0] sel;
      logic [11:0] v;
      k   = (it == 0) ? 0 : (it == 1) ? 7 : $urandom_range(0, 7);
      sel = 2'($urandom_range(0, 2));
      n   = 16 >> sel;
      v   = 12'($urandom_range(0, 4095));
      code = v[11:4];
      part = (code & ~(8'hFF >> k)) | (8'h80 >> k);
      start_conv(v, sel, 1'b0);
      wait_cyc((2 + k) * n);
      chk(dac_code == part, "R4", "trial code mid conversion", dac_code, part);
      d0 = done_cnt;
      wr(cw(1'b0, 1'b1, sel, 2'b00));
      chk(result_q == part, "R6", "partial result after abort", result_q, part);
      chk(ctrl_q[7] == 1'b0, "R6", "busy low after abort", ctrl_q[7], 0);
      wait_cyc(12 * n);
      chk(result_q == part && done_cnt == d0, "R6", "partial held, no done", result_q, part);
    end

    // R9 abort on the final decision edge
    begin
      logic [11:0] v;
      v = 12'($urandom_range(0, 4095)) | 12'h010;
      code = v[11:4];
      part = (code & 8'hFE) | 8'h01;
      start_conv(v, 2'b10, 1'b0);
      wait_cyc(10 * 4 - 1);
      chk(dac_code == part, "R9", "trial before last decision", dac_code, part);
      d0 = done_cnt;
      wr(cw(1'b0, 1'b1, 2'b10, 2'b00));
      chk(result_q == part && ctrl_q[7] == 1'b0, "R9", "abort beats completion", result_q, part);
      wait_cyc(20);
      chk(done_cnt == d0, "R9", "no done pulse", done_cnt, d0);
    end

    // R10 busy write while running has no effect
    nd = done_cnt;
    start_conv(12'hA5C, 2'b01, 1'b1);
    wait_cyc(40);
    wr(cw(1'b1, 1'b1, 2'b01, 2'b00));
    chk(ctrl_q[7] == 1'b1, "R10", "still busy", ctrl_q[7], 1);
    wait_idle();
    chk(done_cnt == nd + 1 && result_q == 8'hA5, "R10", "conversion completed intact", result_q, 8'hA5);

    // R2 enable off stops a conversion; start then refused
    start_conv(12'h3C0, 2'b10, 1'b0);
    wait_cyc(15);
    d0 = done_cnt;
    wr(cw(1'b1, 1'b0, 2'b10, 2'b00));
    chk(ctrl_q[7] == 1'b0 && adc_on == 1'b0, "R2", "enable off clears busy", ctrl_q, 0);
    wr(cw(1'b1, 1'b1, 2'b10, 2'b00));
    chk(ctrl_q[7] == 1'b0, "R2", "start refused right after enable", ctrl_q[7], 0);
    wait_cyc(60);
    chk(done_cnt == d0, "R2", "no done after shutdown", done_cnt, d0);

    chk(q_code.size() == 0, "R5", "all expected completions seen", q_code.size(), 0);
    summary();
    $finish;
  end
endmodule